// File: doc/BRIEF.md
# Colour Lookup Table with Register Loader

This block keeps a 256-entry colour table, each entry made of separate 8-bit red, green and blue components, and fills it through a 16-byte window of 32-bit registers. Software first writes a starting entry number to the pointer register. It then writes colour components to the colour register, one per write, in a fixed red, green, blue rotation. Each component is taken from the top byte of the written word. Once the blue component of an entry is stored, the pointer moves on to the next entry, wrapping from 255 to 0. Several consecutive entries can therefore be loaded with one pointer write followed by a stream of colour writes.

A pixel pipeline reads the table through a separate lookup port. It presents an entry number and receives the packed 24-bit colour on the next clock. After reset, every entry reads as black except the last entry, which reads as white. Loading the reset contents does not require a sweep over the table, so the block is usable in the first cycle after reset.

Top module: `pal_lut_regs`

## Requirements
- R1: After reset, lookups of entries 0 to 254 return 24'h000000 and a lookup of entry 255 returns 24'hFFFFFF.
- R2: A write (bus_valid=1, bus_write=1) at byte offset 0 sets the pointer to bus_wdata[31:24] and puts the rotation back to red.
- R3: Writes at byte offset 4 store bus_wdata[31:24] into the current entry's red, green and blue components in turn.
- R4: After the blue component is stored, the pointer becomes (pointer+1) mod 256 and the rotation returns to red, so 255 is followed by 0.
- R5: Writes at any byte offset other than 0 and 4, and all accesses with bus_write=0, leave the table, the pointer and the rotation unchanged.
- R6: bus_rdata is zero in every cycle, including the cycle after any read of the window.
- R7: lut_rgb shows the entry chosen by lut_index at the preceding rising clock edge, packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R8: A lookup of an entry in the same cycle as a write to that entry returns the contents from before the write.
- R9: A pointer write in the middle of a rotation abandons it. Components already stored stay in place, and the next colour write goes to the red component of the new entry.
- R10: A component not written since reset keeps its reset value while the other components of the same entry change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | An access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| lut_index | input | 8 | Entry to look up |
| lut_rgb | output | 24 | Colour of the entry, one clock later |

## Verification
The assertions assume that the bus offers at most one access per cycle and that the reset is held for at least one rising edge before any access. The stimulus drives one access per clock on the falling edge and asserts reset before the first access. The random mix places pointer writes, colour writes, accesses at unused offsets and reads with lookups on arbitrary entries. Some lookups deliberately fall on the entry being written in the same cycle, and some pointer writes are aimed at 255 so that the wrap to 0 is exercised.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // position in the red, green, blue loading rotation
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned NUM_CH = 3;

  // channel numbers; channel 0 lands in the top byte of the lookup word
  localparam int unsigned CH_RED = 0;
  localparam int unsigned CH_GRN = 1;
  localparam int unsigned CH_BLU = 2;

endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned PTR_OFS = 0,
  parameter int unsigned COL_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ptr_wr,
  output logic              col_wr,
  output logic [COMP_W-1:0] wr_byte,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] PTR_A = ADDR_W'(PTR_OFS);
  localparam logic [ADDR_W-1:0] COL_A = ADDR_W'(COL_OFS);

  logic wr_acc;

  assign wr_acc  = valid && write;
  assign ptr_wr  = wr_acc && (addr == PTR_A);
  assign col_wr  = wr_acc && (addr == COL_A);
  assign wr_byte = wdata[DATA_W-1 -: COMP_W];

  // the window has no readable state
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= '0;
  end

  // R2/R3: one access cannot select both registers
  assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
    !(ptr_wr && col_wr));

endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_wr,
  input  logic              col_wr,
  input  logic [COMP_W-1:0] wr_byte,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [NUM_CH-1:0] ch_we
);

  phase_e phase_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_RED;
      idx_q   <= '0;
    end else if (ptr_wr) begin
      phase_q <= PH_RED;
      idx_q   <= wr_byte[COMP_W-1 -: IDX_W];
    end else if (col_wr) begin
      unique case (phase_q)
        PH_RED:  phase_q <= PH_GRN;
        PH_GRN:  phase_q <= PH_BLU;
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_q + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ch_we = '0;
    if (col_wr) begin
      unique case (phase_q)
        PH_RED:  ch_we[CH_RED] = 1'b1;
        PH_GRN:  ch_we[CH_GRN] = 1'b1;
        default: ch_we[CH_BLU] = 1'b1;
      endcase
    end
  end

  assign cur_idx = idx_q;

  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (rst)
    phase_q != 2'd3);

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> (cur_idx == $past(wr_byte[COMP_W-1 -: IDX_W])) && (phase_q == PH_RED));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (col_wr && !ptr_wr && ch_we[CH_BLU]) |=> (cur_idx == $past(cur_idx) + 1'b1) && (phase_q == PH_RED));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ptr_wr && !col_wr) |=> $stable(cur_idx) && $stable(phase_q));

  assert_one_lane_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_we) && (col_wr == (ch_we != '0)));

endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [COMP_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [COMP_W-1:0] rd_val
);

  localparam int unsigned NENT = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NENT - 1);

  logic [COMP_W-1:0] mem [NENT];
  logic [NENT-1:0]   written_q;
  logic [COMP_W-1:0] mem_rd_q;
  logic              written_rd_q;
  logic              last_rd_q;

  // plain array without reset so it maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_val;
    mem_rd_q <= mem[rd_idx];
  end

  // per-entry "has been written" flags stand in for the reset contents
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q    <= '0;
      written_rd_q <= 1'b0;
      last_rd_q    <= 1'b0;
    end else begin
      if (we) written_q[wr_idx] <= 1'b1;
      written_rd_q <= written_q[rd_idx];
      last_rd_q    <= (rd_idx == LAST);
    end
  end

  assign rd_val = written_rd_q ? mem_rd_q : {COMP_W{last_rd_q}};

  // R1: before any write, the lookup shows the reset colour
  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    (written_q == '0) |=> (rd_val == {COMP_W{last_rd_q}}));

endmodule

// File: rtl/pal_lut_regs.sv
module pal_lut_regs
  import pal_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned PTR_OFS = 0,
  parameter int unsigned COL_OFS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [IDX_W-1:0]         lut_index,
  output logic [NUM_CH*COMP_W-1:0] lut_rgb
);

  logic              ptr_wr;
  logic              col_wr;
  logic [COMP_W-1:0] wr_byte;
  logic [IDX_W-1:0]  cur_idx;
  logic [NUM_CH-1:0] ch_we;

  pal_bus_decode #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .COMP_W (COMP_W),
    .PTR_OFS(PTR_OFS),
    .COL_OFS(COL_OFS)
  ) u_dec (
    .clk    (clk),
    .rst    (rst),
    .valid  (bus_valid),
    .write  (bus_write),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .ptr_wr (ptr_wr),
    .col_wr (col_wr),
    .wr_byte(wr_byte),
    .rdata  (bus_rdata)
  );

  pal_seq #(
    .IDX_W (IDX_W),
    .COMP_W(COMP_W)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .ptr_wr (ptr_wr),
    .col_wr (col_wr),
    .wr_byte(wr_byte),
    .cur_idx(cur_idx),
    .ch_we  (ch_we)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    pal_bank #(
      .IDX_W (IDX_W),
      .COMP_W(COMP_W)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (ch_we[c]),
      .wr_idx(cur_idx),
      .wr_val(wr_byte),
      .rd_idx(lut_index),
      .rd_val(lut_rgb[(NUM_CH-1-c)*COMP_W +: COMP_W])
    );
  end

  assert_rdata_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid && !bus_write) |-> (bus_rdata == '0));

endmodule

// File: tb/test_pal_lut_regs.sv
`timescale 1ns/1ps
module test_pal_lut_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid;
  logic        bus_write;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  lut_index;
  logic [23:0] lut_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the table, pointer and rotation
  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_ph;

  always #4 clk = ~clk;

  pal_lut_regs i_pal_lut_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lut_index(lut_index), .lut_rgb(lut_rgb)
  );

  function automatic logic [23:0] model_rgb(input logic [7:0] i);
    return {m_r[i], m_g[i], m_b[i]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_r[i] = (i == 255) ? 8'hFF : 8'h00;
      m_g[i] = (i == 255) ? 8'hFF : 8'h00;
      m_b[i] = (i == 255) ? 8'hFF : 8'h00;
    end
    m_idx = 8'h00;
    m_ph  = 0;
  endtask

  task automatic model_access(input bit v, input bit w, input logic [3:0] a, input logic [31:0] d);
    if (v && w && a == 4'h0) begin
      m_idx = d[31:24];
      m_ph  = 0;
    end else if (v && w && a == 4'h4) begin
      case (m_ph)
        0: m_r[m_idx] = d[31:24];
        1: m_g[m_idx] = d[31:24];
        default: m_b[m_idx] = d[31:24];
      endcase
      if (m_ph == 2) begin
        m_ph  = 0;
        m_idx = m_idx + 8'd1;
      end else begin
        m_ph = m_ph + 1;
      end
    end
  endtask

  task automatic check24(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, compare lookup at the next falling edge
  task automatic step(input bit v, input bit w, input logic [3:0] a, input logic [31:0] d,
                      input logic [7:0] li, input string tag);
    logic [23:0] exp;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; lut_index = li;
    exp = model_rgb(li);       // read happens before the write lands
    model_access(v, w, a, d);
    @(negedge clk);
    check24(tag, lut_rgb, exp);
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R6: bus_rdata actual %08h expected 00000000", bus_rdata);
    end
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0; lut_index = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic look(input logic [7:0] li, input string tag);
    step(1'b0, 1'b0, 4'h0, 32'h0, li, tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R1: reset contents over the whole table
    for (int i = 0; i < 256; i++) look(8'(i), "R1");

    // R2, R3: load entry 5 and read it back; R7 packing
    step(1, 1, 4'h0, 32'h05AB_CDEF, 8'h00, "R2");
    step(1, 1, 4'h4, 32'h11FF_FFFF, 8'h05, "R3");
    step(1, 1, 4'h4, 32'h2200_0000, 8'h05, "R3");
    step(1, 1, 4'h4, 32'h3300_0000, 8'h05, "R8"); // same-cycle lookup sees old blue
    look(8'h05, "R7");
    check24("R3", lut_rgb, 24'h112233);

    // R4: the next colour lands in entry 6
    step(1, 1, 4'h4, 32'h4400_0000, 8'h06, "R8");
    look(8'h06, "R4");

    // R4: wrap from 255 to 0; R10 partial writes over a white entry
    step(1, 1, 4'h0, 32'hFF00_0000, 8'hFF, "R2");
    step(1, 1, 4'h4, 32'h1200_0000, 8'hFF, "R10");
    look(8'hFF, "R10");
    check24("R10", lut_rgb, 24'h12FFFF);
    step(1, 1, 4'h4, 32'h3400_0000, 8'h00, "R3");
    step(1, 1, 4'h4, 32'h5600_0000, 8'h00, "R3");
    step(1, 1, 4'h4, 32'h7700_0000, 8'h00, "R4");
    look(8'h00, "R4");
    check24("R4", lut_rgb, 24'h770000);

    // R9: pointer write in mid rotation
    step(1, 1, 4'h0, 32'h1000_0000, 8'h10, "R2");
    step(1, 1, 4'h4, 32'hAA00_0000, 8'h10, "R9");
    step(1, 1, 4'h0, 32'h2000_0000, 8'h10, "R9");
    step(1, 1, 4'h4, 32'hBB00_0000, 8'h20, "R9");
    look(8'h10, "R9");
    check24("R9", lut_rgb, 24'hAA0000);
    look(8'h20, "R9");
    check24("R9", lut_rgb, 24'hBB0000);

    // R5: stray offsets and reads change nothing; rotation continues at green
    step(1, 1, 4'h8, 32'hEE00_0000, 8'h20, "R5");
    step(1, 1, 4'hC, 32'hEE00_0000, 8'h20, "R5");
    step(1, 1, 4'h1, 32'hEE00_0000, 8'h20, "R5");
    step(1, 0, 4'h4, 32'hEE00_0000, 8'h20, "R6");
    step(1, 0, 4'h0, 32'hEE00_0000, 8'h20, "R6");
    step(1, 1, 4'h4, 32'hCC00_0000, 8'h20, "R5");
    look(8'h20, "R5");
    check24("R5", lut_rgb, 24'hBBCC00);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [3:0]  a;
      logic [31:0] d;
      logic [7:0]  li;
      sel = $urandom_range(0, 9);
      d   = $urandom();
      if (sel == 0) d[31:24] = 8'hFF;
      a   = (sel < 2) ? 4'h0 : (sel < 7) ? 4'h4 : 4'($urandom_range(0, 15));
      li  = ($urandom_range(0, 2) == 0) ? m_idx : 8'($urandom_range(0, 255));
      step(sel != 9, $urandom_range(0, 5) != 0, a, d, li, "R7");
    end

    // R10 again after a fresh reset
    do_reset();
    step(1, 1, 4'h0, 32'h0300_0000, 8'h03, "R2");
    step(1, 1, 4'h4, 32'h0000_0000, 8'h03, "R3");
    step(1, 1, 4'h4, 32'h9900_0000, 8'h03, "R3");
    look(8'h03, "R10");
    check24("R10", lut_rgb, 24'h009900);
    look(8'hFF, "R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule